// File: doc/BRIEF.md
# 40-bit Free-Running Time Base

This block keeps a 40-bit count that grows by one on every cycle where a tick strobe is high and counting has been switched on. The tick strobe comes from outside the block and runs at about 983 kHz. Software reads the count as a monotonic time base through two 32-bit registers on a simple register port. The low-word register returns count bits 31:0. The high-word register returns count bits 39:32 in its low byte, the enable state in bit 8, and zeros above that. The block has no reload and no interrupt, and the count wraps from all ones back to zero.

A 40-bit value cannot be read in one 32-bit access. Reading the low word therefore copies the top eight count bits into a shadow byte. The next high-word read returns that shadow byte and not the live bits. A carry out of bit 31 between the two reads cannot give software a torn value. The enable bit sits in the same high-word register. Writing it as 0 stops the count where it is and does not clear it.

Each read access returns its data on `rd_data` together with a one-cycle `rd_valid` pulse in the following cycle. Write accesses produce no response.

Top module: `freerun_tbase40`

## Requirements
- R1: After reset the count equals the `CNT_INIT` parameter (all zeros by default), counting is disabled, the shadow byte is zero, and `rd_valid` is low.
- R2: While enabled, the count rises by exactly one on each clock where `tick_en` is high and holds when `tick_en` is low. It wraps from all ones to all zeros.
- R3: A read at offset 0x60 returns count bits 31:0 as they stood in the access cycle, before that cycle's tick. The data appears on `rd_data` in the next cycle.
- R4: A write at offset 0x64 sets the enable from write-data bit 8. The new value applies from the cycle after the write; a tick in the write cycle itself uses the old enable. Writing 0 freezes the count without clearing it.
- R5: A read at offset 0x60 copies count bits 39:32 into the shadow byte. A read at offset 0x64 returns the shadow byte in bits 7:0, even if the count has carried since the low read.
- R6: A read at offset 0x64 returns the enable state in bit 8 and zeros in bits 31:9.
- R7: Writes to offset 0x60 or to any unmapped offset change nothing. Reads from unmapped offsets return zero. Every read gives exactly one `rd_valid` pulse in the next cycle, and writes give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count strobe, one cycle wide per time-base tick |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | ADDR_W (8) | Byte offset of the register |
| acc_wdata | input | DATA_W (32) | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | DATA_W (32) | Read data |

## Verification
A register access and a count tick can fall in the same cycle. The bench provokes this in two ways: it raises `tick_en` during low-word reads and during enable writes, and it starts the count just below the wrap point. A low read can then return all ones in the low word while the next cycle's tick carries into the top byte. The scoreboard model takes the read value and the shadow byte from the count before the tick, and it applies a new enable only from the next cycle. The bench checks that the following high read returns the pre-carry byte and that the tick in the write cycle followed the old enable.

// File: rtl/tb40_pkg.sv
package tb40_pkg;

    // Register selection resulting from address decode
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_MISS = 2'd3
    } sel_e;

endpackage

// File: rtl/tb40_decode.sv
module tb40_decode
    import tb40_pkg::*;
#(
    parameter int unsigned          ADDR_W = 8,
    parameter logic [ADDR_W-1:0]    LO_OFS = 8'h60,
    parameter logic [ADDR_W-1:0]    HI_OFS = 8'h64
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);

    always_comb begin
        if (!valid) begin
            sel = SEL_NONE;
        end else if (addr == LO_OFS) begin
            sel = SEL_LO;
        end else if (addr == HI_OFS) begin
            sel = SEL_HI;
        end else begin
            sel = SEL_MISS;
        end
    end

endmodule

// File: rtl/tb40_count.sv
module tb40_count #(
    parameter int unsigned         CNT_W    = 40,
    parameter logic [CNT_W-1:0]    CNT_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            // natural modulo-2^CNT_W wrap
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/tb40_regs.sv
module tb40_regs
    import tb40_pkg::*;
#(
    parameter int unsigned CNT_W  = 40,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned EN_BIT = 8,
    localparam int unsigned HI_W  = CNT_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sel_e              sel,
    input  logic              write,
    input  logic              wr_en_bit,
    input  logic [CNT_W-1:0]  cnt,
    output logic              en,
    output logic [HI_W-1:0]   shadow,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic              en;
        logic [HI_W-1:0]   shadow;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        unique case (sel)
            SEL_LO: begin
                if (!write) begin
                    st_d.rvalid = 1'b1;
                    st_d.rdata  = cnt[DATA_W-1:0];
                    st_d.shadow = cnt[CNT_W-1:DATA_W];
                end
            end
            SEL_HI: begin
                if (write) begin
                    st_d.en = wr_en_bit;
                end else begin
                    st_d.rvalid           = 1'b1;
                    st_d.rdata            = '0;
                    st_d.rdata[HI_W-1:0]  = st_q.shadow;
                    st_d.rdata[EN_BIT]    = st_q.en;
                end
            end
            SEL_MISS: begin
                if (!write) begin
                    st_d.rvalid = 1'b1;
                    st_d.rdata  = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en     = st_q.en;
    assign shadow = st_q.shadow;
    assign rvalid = st_q.rvalid;
    assign rdata  = st_q.rdata;

endmodule

// File: rtl/freerun_tbase40.sv
module freerun_tbase40
    import tb40_pkg::*;
#(
    parameter int unsigned         CNT_W    = 40,
    parameter int unsigned         DATA_W   = 32,
    parameter int unsigned         ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]   LO_OFS   = 8'h60,
    parameter logic [ADDR_W-1:0]   HI_OFS   = 8'h64,
    parameter int unsigned         EN_BIT   = 8,
    parameter logic [CNT_W-1:0]    CNT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned HI_W = CNT_W - DATA_W;

    sel_e             sel_w;
    logic [CNT_W-1:0] cnt_w;
    logic             en_w;
    logic [HI_W-1:0]  shadow_w;
    logic             unused_wdata;

    assign unused_wdata = ^acc_wdata;

    tb40_decode #(
        .ADDR_W (ADDR_W),
        .LO_OFS (LO_OFS),
        .HI_OFS (HI_OFS)
    ) u_dec (
        .valid (acc_valid),
        .addr  (acc_addr),
        .sel   (sel_w)
    );

    tb40_count #(
        .CNT_W    (CNT_W),
        .CNT_INIT (CNT_INIT)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (en_w & tick_en),
        .cnt   (cnt_w)
    );

    tb40_regs #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .EN_BIT (EN_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel_w),
        .write     (acc_write),
        .wr_en_bit (acc_wdata[EN_BIT]),
        .cnt       (cnt_w),
        .en        (en_w),
        .shadow    (shadow_w),
        .rvalid    (rd_valid),
        .rdata     (rd_data)
    );

endmodule

// File: rtl/freerun_tbase40_chk.sv
module freerun_tbase40_chk #(
    parameter int unsigned         CNT_W  = 40,
    parameter int unsigned         DATA_W = 32,
    parameter int unsigned         ADDR_W = 8,
    parameter logic [ADDR_W-1:0]   LO_OFS = 8'h60,
    parameter logic [ADDR_W-1:0]   HI_OFS = 8'h64,
    parameter int unsigned         EN_BIT = 8,
    localparam int unsigned        HI_W   = CNT_W - DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  cnt,
    input logic              en,
    input logic [HI_W-1:0]   shadow
);

    logic rd_lo, rd_hi, wr_hi, wr_lo;
    assign rd_lo = acc_valid && !acc_write && (acc_addr == LO_OFS);
    assign rd_hi = acc_valid && !acc_write && (acc_addr == HI_OFS);
    assign wr_hi = acc_valid &&  acc_write && (acc_addr == HI_OFS);
    assign wr_lo = acc_valid &&  acc_write && (acc_addr == LO_OFS);

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick_en) |=> (cnt == $past(cnt) + 1'b1)); // R2

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt)); // R2

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt)); // R4

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (en == $past(acc_wdata[EN_BIT]))); // R4

    AST_LO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (rd_valid && rd_data == $past(cnt[DATA_W-1:0]))); // R3

    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (shadow == $past(cnt[CNT_W-1:DATA_W]))); // R5

    AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> (rd_data[DATA_W-1:EN_BIT+1] == '0 && rd_data[EN_BIT] == $past(en))); // R6

    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> !rd_valid); // R7

    AST_LO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> $stable(en)); // R7

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rd_valid); // R7

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!rd_valid && !en); // R1
        end
    end

endmodule

bind freerun_tbase40 freerun_tbase40_chk #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .LO_OFS (LO_OFS),
    .HI_OFS (HI_OFS),
    .EN_BIT (EN_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .cnt       (cnt_w),
    .en        (en_w),
    .shadow    (shadow_w)
);

// File: tb/sim_freerun_tbase40.sv
module sim_freerun_tbase40;

    localparam logic [39:0] INIT = 40'hFF_FFFF_FFF0;
    localparam logic [7:0]  LO   = 8'h60;
    localparam logic [7:0]  HI   = 8'h64;
    localparam logic [7:0]  MISS = 8'h68;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    logic [39:0] m_cnt = INIT;
    logic        m_en = 1'b0;
    logic [7:0]  m_shadow = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    freerun_tbase40 #(.CNT_INIT(INIT)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // driver: one cycle of stimulus, pushes expectation for reads
    task automatic step(input logic tk, input logic v, input logic w,
                        input logic [7:0] a, input logic [31:0] wd, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        tick_en   = tk;
        acc_valid = v;
        acc_write = w;
        acc_addr  = a;
        acc_wdata = wd;
        if (v && !w) begin
            if (a == LO)      exp = m_cnt[31:0];
            else if (a == HI) exp = {23'd0, m_en, m_shadow};
            else              exp = 32'd0;
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        if (v && !w && a == LO) m_shadow = m_cnt[39:32];
        if (m_en && tk)         m_cnt    = m_cnt + 40'd1;
        if (v && w && a == HI)  m_en     = wd[8];
    endtask

    task automatic idle(input int n, input logic tk);
        for (int i = 0; i < n; i++) step(tk, 1'b0, 1'b0, 8'h00, 32'd0, "");
    endtask

    // monitor: compares each read response against the queue
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R7 unexpected rd_valid actual=1 expected=0");
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_bad++;
                    $display("FAIL %s read data actual=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;
        if (rd_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 rd_valid in reset actual=%b expected=0", rd_valid);
        end
        rst_n = 1'b1;

        // R1: reset state (shadow zero and enable off, then init count)
        step(1'b0, 1'b1, 1'b0, HI, 32'd0, "R1");
        step(1'b0, 1'b1, 1'b0, LO, 32'd0, "R1");
        // R4: ticks while disabled leave count frozen
        idle(5, 1'b1);
        step(1'b1, 1'b1, 1'b0, LO, 32'd0, "R4");
        // R7: writes to low word and unmapped offset are inert
        step(1'b1, 1'b1, 1'b1, LO, 32'hFFFF_FFFF, "R7");
        step(1'b1, 1'b1, 1'b1, MISS, 32'hFFFF_FFFF, "R7");
        step(1'b1, 1'b1, 1'b0, HI, 32'd0, "R7");
        step(1'b1, 1'b1, 1'b0, LO, 32'd0, "R7");
        step(1'b1, 1'b1, 1'b0, MISS, 32'd0, "R7");
        // R4: enable with a tick in the write cycle (old enable applies)
        step(1'b1, 1'b1, 1'b1, HI, 32'hFFFF_FFFF, "R4");
        // R6: enable visible in bit 8, upper bits zero
        step(1'b0, 1'b1, 1'b0, HI, 32'd0, "R6");
        // R3: low read sampled with a tick in the same cycle
        step(1'b1, 1'b1, 1'b0, LO, 32'd0, "R3");
        step(1'b0, 1'b1, 1'b0, LO, 32'd0, "R3");
        // R2/R5: alternate low/high reads with ticks across the wrap
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 1'b1, 1'b0, LO, 32'd0, "R5");
            step(1'b1, 1'b1, 1'b0, HI, 32'd0, "R5");
        end
        step(1'b0, 1'b1, 1'b0, LO, 32'd0, "R2");
        step(1'b0, 1'b1, 1'b0, HI, 32'd0, "R2");
        // R4: freeze keeps value, then resume
        step(1'b1, 1'b1, 1'b1, HI, 32'h0000_0000, "R4");
        idle(6, 1'b1);
        step(1'b1, 1'b1, 1'b0, LO, 32'd0, "R4");
        step(1'b1, 1'b1, 1'b0, HI, 32'd0, "R4");
        step(1'b0, 1'b1, 1'b1, HI, 32'h0000_0100, "R4");
        // R2: irregular tick pattern with periodic reads
        for (int i = 0; i < 200; i++) begin
            if (i % 7 == 0)
                step((i % 3) != 0, 1'b1, 1'b0, LO, 32'd0, "R2");
            else if (i % 7 == 1)
                step((i % 3) != 0, 1'b1, 1'b0, HI, 32'd0, "R2");
            else
                step((i % 3) != 0, 1'b0, 1'b0, 8'h00, 32'd0, "");
        end
        idle(4, 1'b0);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7 missing responses actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule